// File: doc/BRIEF.md
# Video Memory Write FIFO Dispatcher

This block is the data-port path of a tile-based video display processor. A host loads an access code and a 16-bit access address, then writes 16-bit words to the data port. Each accepted word goes into a four-entry queue. The entry also stores a copy of the address and code that were current when the word arrived, and a timestamp in master-clock cycles. The address register then moves forward by the auto-increment amount.

A drain engine takes at most one step per drain-slot strobe. It commits the head entry to one of three internal memories: a byte-wide video RAM, a 16-bit colour RAM or a 16-bit vertical-scroll RAM. The entry's own stored code picks the memory. When DMA is enabled and the entry's code asks for a DMA start, the engine does not write memory. It raises a start flag, latches the value and code, and restores the address register to the entry's captured address.

Data-port reads are gated by the code register. A write code answers zero at once. A read code waits for the queue to empty, then returns the addressed word.

Top module: `vfd_dispatch`

## Requirements
- R1: After reset, `wr_stall`, `pending`, `rd_valid`, `dma_start` and `retire_valid` are 0, and `cur_addr` is 0.
- R2: An accepted data write (`wr_en` while `wr_stall` is 0) stores the current address and code with the word. The address register then advances by `autoinc`. `wr_stall` is 1 when four entries are queued, and a write made while it is 1 is ignored. An ignored write leaves the address register and the queue unchanged.
- R3: An entry with code bits [3:0] = 0001 (video RAM write) takes two drain steps. The first step writes bits [15:8] at the entry address and keeps the entry queued. The second step writes bits [7:0] at the entry address XOR 1, then removes the entry.
- R4: An entry with code bits [3:0] = 0011 (colour RAM write) writes its word at index (address / 2) mod 64.
- R5: An entry with code bits [3:0] = 0101 (vertical-scroll RAM write) uses index (address / 2) AND 63. The write is dropped when the index is 40 or more. A vertical-scroll read at such an index returns 0.
- R6: The memory target comes from the code stored in the entry. A code load made after the entry was queued does not change where the entry goes.
- R7: When `dma_en` is 1 and the head entry's code bit 5 is 1, a drain step removes the entry without writing any memory. On the following cycle `dma_start` pulses, `dma_val` and `dma_code` hold the entry's word and code, and `cur_addr` equals the entry's captured address. This restore takes priority over the increment of a concurrent write.
- R8: A read (`rd_req`) while bit 0 of the code register is 1 returns 0 on `rd_data`, and does not wait for the queue to empty.
- R9: A read clears `pending`. With bit 0 of the code clear, the read does not respond while entries are queued. Once the queue is empty it returns the addressed word, selected by code bits [3:0]: 0000 for video RAM, 1000 for colour RAM, 0100 for vertical-scroll RAM. A video RAM read returns {byte at address, byte at address XOR 1}.
- R10: Each removed entry pulses `retire_valid` with `retire_ts` equal to seven times the `host_cyc` value sampled at its write.
- R11: The drain engine takes at most one step per `drain_slot` cycle. An enqueue and a removal in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_half | input | 1 | First half of a control word seen; sets pending |
| ctl_load | input | 1 | Load code and address registers |
| ctl_code | input | 6 | Access code to load (bit 5 DMA start, bits 3:0 operation) |
| ctl_addr | input | 16 | Access address to load |
| autoinc | input | 8 | Auto-increment amount |
| dma_en | input | 1 | DMA enable from the mode settings |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 16 | Data-port write word |
| host_cyc | input | 16 | Host CPU cycle count for the timestamp |
| wr_stall | output | 1 | Queue full; writes are ignored |
| rd_req | input | 1 | Data-port read request |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 16 | Read response word |
| drain_slot | input | 1 | Drain-slot strobe |
| pending | output | 1 | Control-word pending flag |
| cur_addr | output | 16 | Address register |
| dma_start | output | 1 | DMA run start pulse |
| dma_val | output | 16 | Word latched for the DMA engine |
| dma_code | output | 6 | Code latched for the DMA engine |
| retire_valid | output | 1 | Entry removed from the queue |
| retire_ts | output | 19 | Master-clock timestamp of the removed entry |

## Verification
The two functions that can meet in one cycle are an enqueue and a drain removal. A third case is a DMA address restore arriving on the same edge as the auto-increment of a new write. Back-to-back colour RAM writes are issued while `drain_slot` is held high, so each edge both pushes and pops. The bench judges this by reading every word back from its own index, by the retire timestamps arriving in write order, and by `wr_stall` never rising. A fill with single drain pulses shows that the first half of a video RAM entry keeps the queue full. A read held while entries are queued shows the wait.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CODE_W = 6;
  localparam int CYC_W  = 16;
  localparam int TS_W   = CYC_W + 3;
  localparam int AINC_W = 8;
  localparam int DMA_BIT = 5;

  localparam logic [3:0] OP_VRAM_WR = 4'b0001;
  localparam logic [3:0] OP_CRAM_WR = 4'b0011;
  localparam logic [3:0] OP_VS_WR   = 4'b0101;
  localparam logic [3:0] OP_VRAM_RD = 4'b0000;
  localparam logic [3:0] OP_CRAM_RD = 4'b1000;
  localparam logic [3:0] OP_VS_RD   = 4'b0100;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] val;
    logic [CODE_W-1:0] code;
    logic              partial;
  } fent_t;
endpackage

// File: rtl/vfd_fifo.sv
module vfd_fifo
  import vfd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  fent_t push_ent,
  input  logic  pop,
  input  logic  set_partial,
  output fent_t head,
  output logic  full,
  output logic  empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  fent_t            slot_q [DEPTH];

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d = push ? step_ptr(wr_q) : wr_q;
    rd_d = pop  ? step_ptr(rd_q) : rd_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_ent;
    if (set_partial) slot_q[rd_q].partial <= 1'b1;
  end

  assign head  = slot_q[rd_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R2
  AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R11
  AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> cnt_q == $past(cnt_q) + 1'b1); // R11
  AST_CNT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q)); // R11
  AST_PARTIAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    set_partial |=> (!empty && head.partial)); // R3
endmodule

// File: rtl/vfd_drain.sv
module vfd_drain
  import vfd_pkg::*;
#(
  parameter int VRAM_AW  = 8,
  parameter int CRAM_AW  = 6,
  parameter int VS_DEPTH = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot,
  input  logic               empty,
  input  fent_t              head,
  input  logic               dma_en,
  output logic               pop,
  output logic               set_partial,
  output logic               dma_go,
  output logic               vram_we,
  output logic [VRAM_AW-1:0] vram_idx,
  output logic [7:0]         vram_byte,
  output logic               cram_we,
  output logic [CRAM_AW-1:0] cram_idx,
  output logic               vs_we,
  output logic [5:0]         vs_idx,
  output logic [DATA_W-1:0]  wword,
  output logic               dma_start,
  output logic [DATA_W-1:0]  dma_val,
  output logic [CODE_W-1:0]  dma_code,
  output logic               retire_valid,
  output logic [TS_W-1:0]    retire_ts
);
  localparam logic [6:0] VS_LIM = 7'(VS_DEPTH);

  logic              step;
  logic              dma_start_q;
  logic [DATA_W-1:0] dma_val_q;
  logic [CODE_W-1:0] dma_code_q;
  logic              ret_q;
  logic [TS_W-1:0]   ts_q;
  logic              unused_head;

  assign unused_head = ^head;
  assign step     = slot && !empty;
  assign cram_idx = head.addr[CRAM_AW:1];
  assign vs_idx   = head.addr[6:1];
  assign wword    = head.val;

  always_comb begin
    pop         = 1'b0;
    set_partial = 1'b0;
    dma_go      = 1'b0;
    vram_we     = 1'b0;
    cram_we     = 1'b0;
    vs_we       = 1'b0;
    vram_idx    = head.addr[VRAM_AW-1:0];
    vram_byte   = head.val[15:8];
    if (step) begin
      if (dma_en && head.code[DMA_BIT]) begin
        dma_go = 1'b1;
        pop    = 1'b1;
      end else begin
        case (head.code[3:0])
          OP_VRAM_WR: begin
            vram_we = 1'b1;
            if (!head.partial) begin
              set_partial = 1'b1;
            end else begin
              vram_idx  = head.addr[VRAM_AW-1:0] ^ VRAM_AW'(1);
              vram_byte = head.val[7:0];
              pop       = 1'b1;
            end
          end
          OP_CRAM_WR: begin
            cram_we = 1'b1;
            pop     = 1'b1;
          end
          OP_VS_WR: begin
            vs_we = ({1'b0, head.addr[6:1]} < VS_LIM);
            pop   = 1'b1;
          end
          default: pop = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_start_q <= 1'b0;
      ret_q       <= 1'b0;
    end else begin
      dma_start_q <= dma_go;
      ret_q       <= pop;
    end
  end

  always_ff @(posedge clk) begin
    if (dma_go) begin
      dma_val_q  <= head.val;
      dma_code_q <= head.code;
    end
    if (pop) ts_q <= head.ts;
  end

  assign dma_start    = dma_start_q;
  assign dma_val      = dma_val_q;
  assign dma_code     = dma_code_q;
  assign retire_valid = ret_q;
  assign retire_ts    = ts_q;

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |-> !(pop || set_partial || vram_we || cram_we || vs_we)); // R11
endmodule

// File: rtl/vfd_mems.sv
module vfd_mems
  import vfd_pkg::*;
#(
  parameter int VRAM_AW  = 8,
  parameter int CRAM_AW  = 6,
  parameter int VS_DEPTH = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vram_we,
  input  logic [VRAM_AW-1:0] vram_idx,
  input  logic [7:0]         vram_byte,
  input  logic               cram_we,
  input  logic [CRAM_AW-1:0] cram_idx,
  input  logic               vs_we,
  input  logic [5:0]         vs_idx,
  input  logic [DATA_W-1:0]  wword,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [3:0]         rd_op,
  output logic [DATA_W-1:0]  rd_word
);
  localparam int VRAM_N = 2 ** VRAM_AW;
  localparam int CRAM_N = 2 ** CRAM_AW;
  localparam logic [6:0] VS_LIM = 7'(VS_DEPTH);

  logic [7:0]        vram  [VRAM_N];
  logic [DATA_W-1:0] cram  [CRAM_N];
  logic [DATA_W-1:0] vsram [VS_DEPTH];

  logic [VRAM_AW-1:0] ra_v;
  logic [5:0]         ra_s;
  logic               unused_raddr;

  assign unused_raddr = ^rd_addr;
  assign ra_v = rd_addr[VRAM_AW-1:0];
  assign ra_s = rd_addr[6:1];

  always_ff @(posedge clk) begin
    if (vram_we) vram[vram_idx] <= vram_byte;
    if (cram_we) cram[cram_idx] <= wword;
    if (vs_we)   vsram[vs_idx]  <= wword;
  end

  always_comb begin
    case (rd_op)
      OP_VRAM_RD: rd_word = {vram[ra_v], vram[ra_v ^ VRAM_AW'(1)]};
      OP_CRAM_RD: rd_word = cram[rd_addr[CRAM_AW:1]];
      OP_VS_RD:   rd_word = ({1'b0, ra_s} < VS_LIM) ? vsram[ra_s] : '0;
      default:    rd_word = '0;
    endcase
  end

  AST_VS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vs_we |-> ({1'b0, vs_idx} < VS_LIM)); // R5
  AST_ONE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({vram_we, cram_we, vs_we}) <= 1); // R6
endmodule

// File: rtl/vfd_dispatch.sv
module vfd_dispatch
  import vfd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int VRAM_AW    = 8,
  parameter int CRAM_AW    = 6,
  parameter int VS_DEPTH   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_half,
  input  logic              ctl_load,
  input  logic [CODE_W-1:0] ctl_code,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [AINC_W-1:0] autoinc,
  input  logic              dma_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CYC_W-1:0]  host_cyc,
  output logic              wr_stall,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              drain_slot,
  output logic              pending,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              dma_start,
  output logic [DATA_W-1:0] dma_val,
  output logic [CODE_W-1:0] dma_code,
  output logic              retire_valid,
  output logic [TS_W-1:0]   retire_ts
);
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              pend_q, pend_d;
  logic              busy_q, busy_d;
  logic              rv_q, rsp;
  logic [DATA_W-1:0] rdat_q, rdat_d, mem_word;
  logic              push, full, empty, pop, set_partial, dma_go;
  fent_t             new_ent, head;
  logic               vram_we, cram_we, vs_we;
  logic [VRAM_AW-1:0] vram_idx;
  logic [7:0]         vram_byte;
  logic [CRAM_AW-1:0] cram_idx;
  logic [5:0]         vs_idx;
  logic [DATA_W-1:0]  wword;
  logic               unused_code;

  assign unused_code = ^code_q[CODE_W-1:4];
  assign push = wr_en && !full;

  always_comb begin
    new_ent.ts      = TS_W'({host_cyc, 3'b000}) - TS_W'(host_cyc);
    new_ent.addr    = addr_q;
    new_ent.val     = wr_data;
    new_ent.code    = code_q;
    new_ent.partial = 1'b0;
  end

  always_comb begin
    if (ctl_load)    addr_d = ctl_addr;
    else if (dma_go) addr_d = head.addr;
    else if (push)   addr_d = addr_q + ADDR_W'(autoinc);
    else             addr_d = addr_q;
    code_d = ctl_load ? ctl_code : code_q;
    if (ctl_load || push || rd_req) pend_d = 1'b0;
    else if (ctl_half)              pend_d = 1'b1;
    else                            pend_d = pend_q;
    rsp    = busy_q && (code_q[0] || empty);
    rdat_d = code_q[0] ? '0 : mem_word;
    if (rd_req && !busy_q) busy_d = 1'b1;
    else if (rsp)          busy_d = 1'b0;
    else                   busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q <= '0;
      code_q <= '0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      code_q <= code_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
      rv_q   <= rsp;
      if (rsp) rdat_q <= rdat_d;
    end
  end

  vfd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push(push), .push_ent(new_ent), .pop(pop),
    .set_partial(set_partial), .head(head), .full(full), .empty(empty)
  );

  vfd_drain #(.VRAM_AW(VRAM_AW), .CRAM_AW(CRAM_AW), .VS_DEPTH(VS_DEPTH)) u_drain (
    .clk(clk), .rst_n(rst_s), .slot(drain_slot), .empty(empty), .head(head),
    .dma_en(dma_en), .pop(pop), .set_partial(set_partial), .dma_go(dma_go),
    .vram_we(vram_we), .vram_idx(vram_idx), .vram_byte(vram_byte),
    .cram_we(cram_we), .cram_idx(cram_idx), .vs_we(vs_we), .vs_idx(vs_idx),
    .wword(wword), .dma_start(dma_start), .dma_val(dma_val), .dma_code(dma_code),
    .retire_valid(retire_valid), .retire_ts(retire_ts)
  );

  vfd_mems #(.VRAM_AW(VRAM_AW), .CRAM_AW(CRAM_AW), .VS_DEPTH(VS_DEPTH)) u_mems (
    .clk(clk), .rst_n(rst_s), .vram_we(vram_we), .vram_idx(vram_idx),
    .vram_byte(vram_byte), .cram_we(cram_we), .cram_idx(cram_idx),
    .vs_we(vs_we), .vs_idx(vs_idx), .wword(wword), .rd_addr(addr_q),
    .rd_op(code_q[3:0]), .rd_word(mem_word)
  );

  assign wr_stall = full;
  assign rd_valid = rv_q;
  assign rd_data  = rdat_q;
  assign pending  = pend_q;
  assign cur_addr = addr_q;

  AST_AINC: assert property (@(posedge clk) disable iff (!rst_s)
    (push && !ctl_load && !dma_go) |=> addr_q == $past(addr_q) + ADDR_W'($past(autoinc))); // R2
  AST_DMA_RESTORE: assert property (@(posedge clk) disable iff (!rst_s)
    (dma_go && !ctl_load) |=> (addr_q == $past(head.addr) && dma_start)); // R7
  AST_READ_GATE: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && code_q[0]) |=> (rd_valid && rd_data == '0)); // R8
  AST_READ_WAIT: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && !code_q[0] && !empty) |=> !rd_valid); // R9
endmodule

// File: tb/tb_vfd_dispatch.sv
`timescale 1ns/1ps
module tb_vfd_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_half, ctl_load, dma_en, wr_en, rd_req, drain_slot;
  logic [5:0]  ctl_code;
  logic [15:0] ctl_addr, wr_data, host_cyc;
  logic [7:0]  autoinc;
  logic        wr_stall, rd_valid, pending, dma_start, retire_valid;
  logic [15:0] rd_data, cur_addr, dma_val;
  logic [5:0]  dma_code;
  logic [18:0] retire_ts;

  always #2 clk = ~clk;

  vfd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .ctl_half(ctl_half), .ctl_load(ctl_load),
    .ctl_code(ctl_code), .ctl_addr(ctl_addr), .autoinc(autoinc), .dma_en(dma_en),
    .wr_en(wr_en), .wr_data(wr_data), .host_cyc(host_cyc), .wr_stall(wr_stall),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .drain_slot(drain_slot), .pending(pending), .cur_addr(cur_addr),
    .dma_start(dma_start), .dma_val(dma_val), .dma_code(dma_code),
    .retire_valid(retire_valid), .retire_ts(retire_ts)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit mon_on = 0;
  logic [15:0] cyc_cnt = 16'h0100;
  logic [15:0] rd_exp[$];
  string       rd_tag[$];
  logic [18:0] ts_exp[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rd_valid) begin
      if (rd_exp.size() == 0) check("R9 unexpected read", 32'd1, 32'd0);
      else begin
        automatic logic [15:0] e = rd_exp.pop_front();
        automatic string t = rd_tag.pop_front();
        check(t, {16'h0, rd_data}, {16'h0, e});
      end
    end
    if (mon_on && retire_valid) begin
      if (ts_exp.size() == 0) check("R10 unexpected retire", 32'd1, 32'd0);
      else begin
        automatic logic [18:0] e = ts_exp.pop_front();
        check("R10 retire_ts", {13'h0, retire_ts}, {13'h0, e});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [5:0] c, input logic [15:0] a);
    ctl_load = 1'b1; ctl_code = c; ctl_addr = a;
    @(negedge clk);
    ctl_load = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    cyc_cnt = cyc_cnt + 16'd37;
    wr_en = 1'b1; wr_data = d; host_cyc = cyc_cnt;
    if (!wr_stall) ts_exp.push_back(19'(cyc_cnt) * 19'd7);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_issue(input logic [15:0] e, input string t);
    rd_exp.push_back(e); rd_tag.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic rd(input logic [15:0] e, input string t);
    rd_issue(e, t);
    for (int i = 0; i < 40 && rd_exp.size() > 0; i++) @(negedge clk);
    check({t, " response arrived"}, rd_exp.size(), 0);
  endtask

  task automatic pulse();
    drain_slot = 1'b1;
    @(negedge clk);
    drain_slot = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ctl_half = 0; ctl_load = 0; ctl_code = 0; ctl_addr = 0;
    autoinc = 8'd2; dma_en = 0; wr_en = 0; wr_data = 0; host_cyc = 0;
    rd_req = 0; drain_slot = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 wr_stall", wr_stall, 0);
    check("R1 pending", pending, 0);
    check("R1 cur_addr", cur_addr, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 dma_start", dma_start, 0);
    check("R1 retire_valid", retire_valid, 0);
    mon_on = 1;

    // R2 fill the queue with video RAM writes, R3 two-step retire
    load(6'h01, 16'h0010);
    wr(16'hA1B2); wr(16'hC3D4); wr(16'hE5F6); wr(16'h0789);
    check("R2 auto-increment at enqueue", cur_addr, 16'h0018);
    check("R2 stall when full", wr_stall, 1);
    wr(16'hDEAD);
    check("R2 ignored write leaves address", cur_addr, 16'h0018);
    pulse();
    check("R3 first half keeps entry", wr_stall, 1);
    pulse();
    check("R3 second half removes entry", wr_stall, 0);
    drain_slot = 1'b1;
    idle(10);
    load(6'h00, 16'h0012);
    rd(16'hC3D4, "R3 video read even");
    load(6'h00, 16'h0013);
    rd(16'hD4C3, "R3 video read odd xor");
    load(6'h00, 16'h0016);
    rd(16'h0789, "R2 ignored write not queued");

    // R11 enqueue and drain in the same cycle
    load(6'h03, 16'h0000);
    for (int i = 1; i <= 6; i++) wr({8'(i), 8'(i)});
    check("R11 no stall under concurrent drain", wr_stall, 0);
    idle(4);
    for (int i = 1; i <= 6; i++) begin
      load(6'h08, 16'(2 * (i - 1)));
      rd({8'(i), 8'(i)}, "R11 word at own index");
    end

    // R4 colour RAM index wrap
    load(6'h03, 16'h0084);
    wr(16'h0EEE);
    idle(3);
    load(6'h08, 16'h0004);
    rd(16'h0EEE, "R4 colour index mask");

    // R5 vertical-scroll index and drop
    load(6'h05, 16'h0006);
    wr(16'h0123);
    load(6'h05, 16'h0086);
    wr(16'h0456);
    load(6'h05, 16'h0050);
    wr(16'h0999);
    idle(3);
    load(6'h04, 16'h0006);
    rd(16'h0456, "R5 vscroll index mask");
    load(6'h04, 16'h0050);
    rd(16'h0000, "R5 vscroll beyond depth");

    // R6 target taken from stored code
    load(6'h05, 16'h0010);
    wr(16'h0777);
    idle(3);
    drain_slot = 1'b0;
    load(6'h03, 16'h0010);
    wr(16'h0BEE);
    load(6'h05, 16'h0010);
    drain_slot = 1'b1;
    idle(4);
    load(6'h08, 16'h0010);
    rd(16'h0BEE, "R6 colour RAM got entry");
    load(6'h04, 16'h0010);
    rd(16'h0777, "R6 vscroll untouched");

    // R7 DMA start
    drain_slot = 1'b0;
    dma_en = 1'b1;
    load(6'h23, 16'h0100);
    wr(16'h5555);
    check("R7 increment before drain", cur_addr, 16'h0102);
    pulse();
    check("R7 dma_start", dma_start, 1);
    check("R7 dma_val", dma_val, 16'h5555);
    check("R7 dma_code", dma_code, 6'h23);
    check("R7 address restored", cur_addr, 16'h0100);
    idle(1);
    check("R7 dma_start one pulse", dma_start, 0);
    dma_en = 1'b0;
    load(6'h08, 16'h0000);
    rd(16'h0101, "R7 no memory write");

    // R8 read with write code answers zero without waiting
    load(6'h01, 16'h0030);
    wr(16'h2468);
    rd(16'h0000, "R8 write code read");
    drain_slot = 1'b1;
    idle(4);
    load(6'h00, 16'h0030);
    rd(16'h2468, "R8 entry still committed");

    // R9 read waits for the queue to empty and clears pending
    drain_slot = 1'b0;
    load(6'h01, 16'h0020);
    wr(16'h1357);
    load(6'h00, 16'h0020);
    ctl_half = 1'b1;
    @(negedge clk);
    ctl_half = 1'b0;
    check("R9 pending set", pending, 1);
    rd_issue(16'h1357, "R9 read after drain");
    idle(6);
    check("R9 read held while queued", rd_exp.size(), 1);
    check("R9 pending cleared", pending, 0);
    drain_slot = 1'b1;
    for (int i = 0; i < 40 && rd_exp.size() > 0; i++) @(negedge clk);
    check("R9 response arrived", rd_exp.size(), 0);

    idle(4);
    check("R10 all retires seen", ts_exp.size(), 0);
    finish_run();
  end
endmodule